// File: doc/BRIEF.md
# SRAM Transfer Splitter and Bank Mapper

This block sits between a host that wants to move a run of bytes to or from external SRAM and the byte-wide command port of that SRAM. The host hands over one request: a 17-bit linear start address, a byte count and a direction. The block then issues one single-byte command per byte, raising the address by one each time. Every command carries a bank number and a 15-bit offset inside that bank.

The external memory is built from 32K chips, so the block never lets a command stream run across a chip edge unmarked. A transfer that spans two or more 32K regions becomes a series of chunks. The first chunk stops exactly at the next 32K boundary, and every later chunk starts at offset zero. Each command is flagged as the opening or closing byte of its chunk where that applies.

The bank comes from the address in a different way for each memory layout. The layout is chosen per request. Write data enters on a valid/ready byte stream. Read bytes return from the SRAM on a second stream and go on to the host on a third. A one-cycle done pulse closes every request, including empty ones.

Top module: `sram_xfer_splitter`

## Requirements
- R1: A request is accepted only when `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, and it stays low from the cycle after a non-empty request is accepted until that request completes.
- R2: A request with length 0 issues no SRAM command. It raises `done` for one cycle, in the cycle after acceptance.
- R3: With `layout` = 2 (four 32K chips, 128K), the command bank equals linear address bits 16:15.
- R4: With `layout` = 1 (two chips, 64K), an address with bit 15 clear maps to bank 2, and an address with bit 15 set maps to bank 1.
- R5: With `layout` = 0 (one chip, 32K), and also with the unused code 3, every command goes to bank 0.
- R6: `cmd_ofs` is the linear address reduced to its low 15 bits. Successive commands of one request step the linear address by exactly one, and a request of N bytes issues exactly N commands.
- R7: `cmd_first` is high on the first command of a request and on every command whose offset is 0. `cmd_last` is high on the final command and on every command whose offset is 0x7FFF. A transfer crossing a 32K boundary therefore ends its first chunk exactly at that boundary.
- R8: For a write (`req_write` = 1), each command carries the write byte present when it is accepted. A write byte is consumed only in the cycle its command is accepted. An offered read command holds its bank and offset until accepted.
- R9: For a read, only one command is outstanding at a time. Each `rsp_data` byte is passed to `rd_data` in order, and the next command waits until the previous response has been taken by the host.
- R10: `done` pulses for exactly one cycle, in the cycle after the final byte's write command or read response is transferred. The block is idle in that cycle.
- R11: The layout is captured when the request is accepted. Changing `layout` during a transfer does not change its bank mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| layout | input | 2 | Memory layout: 0 = 32K, 1 = 64K, 2 = 128K, 3 treated as 32K |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 17 | Linear start address |
| req_len | input | 18 | Byte count (0 allowed) |
| req_write | input | 1 | 1 = write to SRAM, 0 = read from SRAM |
| wdata_valid | input | 1 | Write byte offered by host |
| wdata_ready | output | 1 | Write byte consumed |
| wdata | input | 8 | Write byte |
| cmd_valid | output | 1 | SRAM command offered |
| cmd_ready | input | 1 | SRAM command port accepts |
| cmd_write | output | 1 | Command direction |
| cmd_bank | output | 2 | Bank number |
| cmd_ofs | output | 15 | Offset inside the bank |
| cmd_wdata | output | 8 | Byte to write |
| cmd_first | output | 1 | First byte of a chunk |
| cmd_last | output | 1 | Last byte of a chunk |
| rsp_valid | input | 1 | Read byte returned by SRAM |
| rsp_ready | output | 1 | Read byte taken |
| rsp_data | input | 8 | Returned read byte |
| rd_valid | output | 1 | Read byte offered to host |
| rd_ready | input | 1 | Host takes read byte |
| rd_data | output | 8 | Read byte to host |
| done | output | 1 | One-cycle completion pulse |

## Verification
Transfers are run in each layout with start addresses chosen a few bytes below a 32K boundary. The per-byte bank and chunk flags then show whether the split falls on the exact byte where the bank changes. In the 64K layout the crossing runs from bank 1 into bank 2, which separates the swapped mapping from the plain use of upper address bits. A 32K crossing keeps bank 0 while the offset wraps. A zero-length request, and a layout change made just after acceptance, check that completion needs no access and that the mapping is captured with the request. Stalls on the command port, the write stream and the host read stream are mixed in, so the hold and ordering rules are tried under back-pressure.

// File: rtl/sram_xfer_splitter.sv
module sram_xfer_splitter #(
  parameter int ADDR_W = 17,
  parameter int LEN_W  = 18,
  parameter int CHIP_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        layout,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_write,
  input  logic              wdata_valid,
  output logic              wdata_ready,
  input  logic [DATA_W-1:0] wdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_write,
  output logic [ADDR_W-CHIP_W-1:0] cmd_bank,
  output logic [CHIP_W-1:0] cmd_ofs,
  output logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_first,
  output logic              cmd_last,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              done
);
  localparam int BANK_W = ADDR_W - CHIP_W;
  localparam logic [1:0] LAY_64K  = 2'd1;
  localparam logic [1:0] LAY_128K = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_CMD, S_RSP} st_t;

  st_t               st;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic              wr_q;
  logic [1:0]        lay_q;
  logic              first_q;
  logic              done_q;

  wire req_fire   = req_valid & req_ready;
  wire cmd_fire   = cmd_valid & cmd_ready;
  wire rsp_fire   = rsp_valid & rsp_ready;
  wire step       = (cmd_fire & wr_q) | rsp_fire;
  wire final_byte = (rem_q == LEN_W'(1));

  assign req_ready   = (st == S_IDLE);
  assign cmd_valid   = (st == S_CMD) && (!wr_q || wdata_valid);
  assign wdata_ready = (st == S_CMD) && wr_q && cmd_ready;
  assign rsp_ready   = (st == S_RSP) && rd_ready;
  assign rd_valid    = (st == S_RSP) && rsp_valid;
  assign rd_data     = rsp_data;
  assign cmd_write   = wr_q;
  assign cmd_wdata   = wdata;
  assign cmd_ofs     = addr_q[CHIP_W-1:0];
  assign cmd_first   = first_q | (cmd_ofs == '0);
  assign cmd_last    = final_byte | (&cmd_ofs);
  assign done        = done_q;

  always_comb begin
    unique case (lay_q)
      LAY_128K: cmd_bank = addr_q[ADDR_W-1:CHIP_W];
      LAY_64K:  cmd_bank = addr_q[CHIP_W] ? BANK_W'(1) : BANK_W'(2);
      default:  cmd_bank = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      wr_q    <= 1'b0;
      lay_q   <= '0;
      first_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (req_fire) begin
        addr_q  <= req_addr;
        rem_q   <= req_len;
        wr_q    <= req_write;
        lay_q   <= layout;
        first_q <= 1'b1;
        if (req_len == '0) done_q <= 1'b1;
        else               st     <= S_CMD;
      end
      if (cmd_fire) begin
        first_q <= 1'b0;
        if (!wr_q) st <= S_RSP;
      end
      if (step) begin
        if (final_byte) begin
          st     <= S_IDLE;
          done_q <= 1'b1;
        end else begin
          st     <= S_CMD;
          addr_q <= addr_q + ADDR_W'(1);
          rem_q  <= rem_q - LEN_W'(1);
        end
      end
    end
  end

  p_zero_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && req_len == '0) |=> (done && !cmd_valid));

  p_ofs_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_write && rem_q > LEN_W'(1)) |=> (cmd_ofs == CHIP_W'($past(cmd_ofs) + CHIP_W'(1))));

  p_chunk_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !final_byte && (&cmd_ofs)) |=> cmd_first);

  p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !cmd_write) |=> (cmd_valid && $stable(cmd_ofs) && $stable(cmd_bank)));

  p_one_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !cmd_valid);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
endmodule

// File: tb/sram_xfer_splitter_bench.sv
module sram_xfer_splitter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  layout = 2'd0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [16:0] req_addr = '0;
  logic [17:0] req_len = '0;
  logic        req_write = 1'b0;
  logic        wdata_valid = 1'b0;
  logic        wdata_ready;
  logic [7:0]  wdata = '0;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic        cmd_write;
  logic [1:0]  cmd_bank;
  logic [14:0] cmd_ofs;
  logic [7:0]  cmd_wdata;
  logic        cmd_first, cmd_last;
  logic        rsp_valid = 1'b0;
  logic        rsp_ready;
  logic [7:0]  rsp_data = '0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [7:0]  rd_data;
  logic        done;

  sram_xfer_splitter u_sram_xfer_splitter (
    .clk, .rst_n, .layout, .req_valid, .req_ready, .req_addr, .req_len, .req_write,
    .wdata_valid, .wdata_ready, .wdata, .cmd_valid, .cmd_ready, .cmd_write, .cmd_bank,
    .cmd_ofs, .cmd_wdata, .cmd_first, .cmd_last, .rsp_valid, .rsp_ready, .rsp_data,
    .rd_valid, .rd_ready, .rd_data, .done
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vec = 0, miss = 0;
  int cyc = 0;
  int n_cmd = 0, n_rd = 0, n_done = 0, n_acc = 0;
  int acc_cyc = 0, done_cyc = 0, step_cyc = 0;
  logic [1:0]  c_bank [64];
  logic [14:0] c_ofs  [64];
  logic        c_first[64], c_last[64], c_wr[64];
  logic [7:0]  c_wd   [64];
  logic [7:0]  r_data [64];
  logic [7:0]  wbase = 8'h40;
  int wcnt = 0;
  bit pend = 0, took = 0;
  logic [7:0] pdat = '0;

  function automatic logic [7:0] mem_byte(logic [1:0] b, logic [14:0] o);
    return {b, o[5:0]} ^ 8'h3C;
  endfunction

  function automatic logic [1:0] bank_of(logic [16:0] a, logic [1:0] lay);
    if (lay == 2'd2) return a[16:15];
    if (lay == 2'd1) return a[15] ? 2'd1 : 2'd2;
    return 2'd0;
  endfunction

  // SRAM model, write-stream source and monitor: sample at negedge, drive after posedge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (req_valid && req_ready) begin n_acc++; acc_cyc = cyc; end
      if (cmd_valid && cmd_ready) begin
        if (n_cmd < 64) begin
          c_bank[n_cmd] = cmd_bank; c_ofs[n_cmd] = cmd_ofs; c_first[n_cmd] = cmd_first;
          c_last[n_cmd] = cmd_last; c_wr[n_cmd] = cmd_write; c_wd[n_cmd] = cmd_wdata;
        end
        n_cmd++;
        if (cmd_write) step_cyc = cyc;
        else begin pend = 1; pdat = mem_byte(cmd_bank, cmd_ofs); end
      end
      if (wdata_valid && wdata_ready) wcnt++;
      if (rd_valid && rd_ready) begin
        if (n_rd < 64) r_data[n_rd] = rd_data;
        n_rd++; took = 1; step_cyc = cyc;
      end
      if (done) begin n_done++; done_cyc = cyc; end
      @(posedge clk); #1;
      if (took) begin rsp_valid = 1'b0; took = 0; end
      if (pend) begin rsp_valid = 1'b1; rsp_data = pdat; pend = 0; end
      cmd_ready   = (cyc % 3) != 2;
      wdata_valid = (cyc % 5) != 4;
      rd_ready    = (cyc % 4) != 3;
      wdata       = wbase + 8'(wcnt);
    end
  end

  task automatic chk(int act, int exp, string req, string what);
    vec++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(logic [16:0] a, logic [17:0] n, logic w, logic [1:0] lay);
    int acc0;
    acc0 = n_acc;
    n_cmd = 0; n_rd = 0; n_done = 0; wcnt = 0;
    @(posedge clk); #1;
    req_addr = a; req_len = n; req_write = w; layout = lay; req_valid = 1'b1;
    while (n_acc == acc0) begin @(negedge clk); #2; end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000 && n_done == 0; i++) begin @(negedge clk); #2; end
    repeat (4) @(negedge clk);
    #2;
  endtask

  task automatic check_bytes(logic [16:0] a, int n, logic w, logic [1:0] lay, string rbank);
    chk(n_cmd, n, "R6", "command count");
    chk(n_done, 1, "R10", "done pulses");
    chk(done_cyc, step_cyc + 1, "R10", "done cycle");
    for (int i = 0; i < n && i < 64; i++) begin
      logic [16:0] la;
      la = a + 17'(i);
      chk(c_bank[i], bank_of(la, lay), rbank, $sformatf("bank byte %0d", i));
      chk(c_ofs[i], la[14:0], "R6", $sformatf("offset byte %0d", i));
      chk(c_first[i], (i == 0 || la[14:0] == 0), "R7", $sformatf("first flag byte %0d", i));
      chk(c_last[i], (i == n-1 || la[14:0] == 15'h7FFF), "R7", $sformatf("last flag byte %0d", i));
      chk(c_wr[i], w, "R8", $sformatf("direction byte %0d", i));
      if (w) chk(c_wd[i], 8'(wbase + 8'(i)), "R8", $sformatf("write byte %0d", i));
      else   chk(r_data[i], mem_byte(bank_of(la, lay), la[14:0]), "R9", $sformatf("read byte %0d", i));
    end
    if (!w) chk(n_rd, n, "R9", "read byte count");
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #2;
    chk(req_ready, 1, "R1", "reset req_ready");
    chk(cmd_valid, 0, "R1", "reset cmd_valid");
    chk(done, 0, "R10", "reset done");
  endtask

  task automatic t_zero_len();
    issue(17'h00123, 18'd0, 1'b1, 2'd2);
    wait_done();
    chk(n_done, 1, "R2", "zero-length done count");
    chk(done_cyc, acc_cyc + 1, "R2", "zero-length done cycle");
    chk(n_cmd, 0, "R2", "zero-length commands");
  endtask

  task automatic t_write_128();
    issue(17'h07FF0, 18'd32, 1'b1, 2'd2);
    @(negedge clk); #2;
    chk(req_ready, 0, "R1", "busy req_ready");
    wait_done();
    check_bytes(17'h07FF0, 32, 1'b1, 2'd2, "R3");
  endtask

  task automatic t_write_128_top();
    issue(17'h17FFA, 18'd12, 1'b1, 2'd2);
    wait_done();
    check_bytes(17'h17FFA, 12, 1'b1, 2'd2, "R3");
  endtask

  task automatic t_read_64();
    issue(17'h0FFF8, 18'd16, 1'b0, 2'd1);
    repeat (5) @(negedge clk);
    #2;
    chk(req_ready, 0, "R1", "busy req_ready mid read");
    wait_done();
    check_bytes(17'h0FFF8, 16, 1'b0, 2'd1, "R4");
  endtask

  task automatic t_read_32();
    issue(17'h07FFC, 18'd8, 1'b0, 2'd0);
    wait_done();
    check_bytes(17'h07FFC, 8, 1'b0, 2'd0, "R5");
  endtask

  task automatic t_write_lay3();
    issue(17'h18010, 18'd4, 1'b1, 2'd3);
    wait_done();
    check_bytes(17'h18010, 4, 1'b1, 2'd0, "R5");
  endtask

  task automatic t_layout_hold();
    issue(17'h18000, 18'd6, 1'b0, 2'd2);
    layout = 2'd1;
    wait_done();
    check_bytes(17'h18000, 6, 1'b0, 2'd2, "R11");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miss++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    t_reset();
    t_zero_len();
    t_write_128();
    t_write_128_top();
    t_read_64();
    t_read_32();
    t_write_lay3();
    t_layout_hold();
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule